// File: doc/BRIEF.md
# Even/Odd Split Carry-Save Multiplier

This block multiplies two unsigned operands and returns the full double-width product. It does not feed one operand straight into a single partial-product array. Instead it breaks each operand into two sparse numbers. One number keeps only the bits at even positions and the other keeps only the bits at odd positions. The four cross products between the two operands' halves (even by even, even by odd, odd by even, odd by odd) add up to the true product. Only the multiplier bits that survive the split produce rows, so every sub-product contributes half as many rows as a full product would.

All rows from the four cross products go into one carry-save tree. In each level of that tree, every group of three rows is compressed into a sum row and a carry row, and the carry row is shifted up one place. No carry travels sideways until only two rows remain. A two-level carry-lookahead adder then adds those two rows. It is built from 4-bit groups, with a second lookahead level across each set of four groups.

The block is used as a single-cycle arithmetic unit with one output register. The operand pair presented with `in_valid` high is multiplied, and its product appears with `out_valid` after the next rising clock edge. The operand width `N` is a parameter and must be even and at least 4. The default is 32.

Top module: `eo_csa_mult`

## Requirements
- R1: When `in_valid` is high at a rising edge, `product` after that edge equals the unsigned product `a_in * b_in` as a 2N-bit value, for every operand pair.
- R2: The result of an operand pair is visible one clock edge after capture, and a new pair can be accepted on every cycle.
- R3: After every rising edge with `rst` low, `out_valid` equals the value `in_valid` had at that edge.
- R4: When `in_valid` is low at an edge, `product` keeps its previous value, even if `a_in` and `b_in` change.
- R5: A synchronous active-high `rst` clears `out_valid` to 0 and `product` to 0. If `rst` and `in_valid` are both high at the same edge, reset wins.
- R6: A zero operand gives a zero product, and powers of two multiply exactly (for example 2^31 * 2^31 = 0x4000000000000000 and 2^16 * 2^8 = 0x0000000001000000 when N = 32).
- R7: All-ones times all-ones gives 0xFFFFFFFE00000001 when N = 32.
- R8: Operands with only even-position bits set (0x55555555) or only odd-position bits set (0xAAAAAAAA) multiply exactly, in all four combinations. For N = 32, 0x55555555^2 = 0x1C71C71C38E38E39, 0xAAAAAAAA^2 = 0x71C71C70E38E38E4, and the mixed products are 0x38E38E3871C71C72.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operand pair |
| a_in | input | N | Unsigned multiplicand |
| b_in | input | N | Unsigned multiplier |
| out_valid | output | 1 | High for one cycle after each accepted pair |
| product | output | 2N | Registered unsigned product |

## Verification
Reset and operand capture can land on the same clock edge. The bench provokes this by raising `rst` and `in_valid` together while a non-zero operand pair sits on the inputs. After that edge it expects `out_valid` low and `product` zero, so reset wins. A second collision checks that a held product survives while the operand inputs change under a low `in_valid`. The bench then feeds a long stream of back-to-back random pairs, some masked to a single bit parity. Each pair is compared with a reference multiply one edge after capture.

// File: rtl/eo_mult_pkg.sv
package eo_mult_pkg;

   // rows left after one level of 3:2 compression
   function automatic int rows_after(input int r);
      return 2 * (r / 3) + (r % 3);
   endfunction

   // row count at a given tree level, level 0 being the input rows
   function automatic int level_rows(input int r0, input int lvl);
      int r;
      r = r0;
      for (int i = 0; i < lvl; i++) r = rows_after(r);
      return r;
   endfunction

   // number of compression levels until two rows remain
   function automatic int num_levels(input int r0);
      int r;
      int n;
      r = r0;
      n = 0;
      while (r > 2) begin
         r = rows_after(r);
         n++;
      end
      return n;
   endfunction

   // first index of a level inside the flattened row store
   function automatic int level_base(input int r0, input int lvl);
      int acc;
      acc = 0;
      for (int i = 0; i < lvl; i++) acc += level_rows(r0, i);
      return acc;
   endfunction

   // 4-wide lookahead: carries into positions 1..4 from generate/propagate
   function automatic logic [3:0] look4(input logic [3:0] g, input logic [3:0] p,
                                        input logic cin);
      logic [3:0] c;
      c[0] = g[0] | (p[0] & cin);
      c[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
      c[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & cin);
      c[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
           | (p[3] & p[2] & p[1] & p[0] & cin);
      return c;
   endfunction

endpackage

// File: rtl/eo_parity_split.sv
module eo_parity_split #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] even_part,
   output logic [W-1:0] odd_part
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i % 2 == 0) begin : g_even
         assign even_part[i] = x[i];
         assign odd_part[i]  = 1'b0;
      end else begin : g_odd
         assign even_part[i] = 1'b0;
         assign odd_part[i]  = x[i];
      end
   end
endmodule

// File: rtl/eo_pp_gen.sv
module eo_pp_gen #(
   parameter int N = 32,
   localparam int PW   = 2 * N,
   localparam int HALF = N / 2,
   localparam int ROWS = 4 * HALF
) (
   input  logic [N-1:0]  a,
   input  logic [N-1:0]  b,
   output logic [PW-1:0] rows [ROWS]
);
   logic [N-1:0] a_ev, a_od, b_ev, b_od;

   eo_parity_split #(.W(N)) u_split_a (.x(a), .even_part(a_ev), .odd_part(a_od));
   eo_parity_split #(.W(N)) u_split_b (.x(b), .even_part(b_ev), .odd_part(b_od));

   // q[1] picks the multiplicand half, q[0] the multiplier half
   for (genvar q = 0; q < 4; q++) begin : g_cross
      localparam int MPAR = q % 2;
      logic [N-1:0] mcand;
      logic [N-1:0] mplier;
      assign mcand  = (q / 2 == 1) ? a_od : a_ev;
      assign mplier = (MPAR == 1) ? b_od : b_ev;
      // rows of zero multiplier bits are pruned: only positions of parity MPAR
      for (genvar k = 0; k < HALF; k++) begin : g_row
         localparam int J = 2 * k + MPAR;
         logic [N-1:0] masked;
         assign masked = mcand & {N{mplier[J]}};
         assign rows[q * HALF + k] = {{N{1'b0}}, masked} << J;
      end
   end
endmodule

// File: rtl/eo_csa_row.sv
module eo_csa_row #(
   parameter int W = 64
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   logic [W-1:0] maj;
   assign s   = x ^ y ^ z;
   assign maj = (x & y) | (x & z) | (y & z);
   // carry row moves one weight up; the top carry is beyond 2N and drops
   assign c   = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/eo_csa_tree.sv
module eo_csa_tree
   import eo_mult_pkg::*;
#(
   parameter int W = 64,
   parameter int R = 64,
   localparam int LVLS  = num_levels(R),
   localparam int TOTAL = level_base(R, LVLS + 1)
) (
   input  logic [W-1:0] rows_in [R],
   output logic [W-1:0] sum_row,
   output logic [W-1:0] carry_row
);
   logic [W-1:0] store [TOTAL];

   for (genvar i = 0; i < R; i++) begin : g_load
      assign store[i] = rows_in[i];
   end

   for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
      localparam int PREV = level_rows(R, l - 1);
      localparam int PB   = level_base(R, l - 1);
      localparam int CB   = level_base(R, l);
      localparam int TRI  = PREV / 3;
      localparam int LEFT = PREV % 3;
      for (genvar t = 0; t < TRI; t++) begin : g_csa
         eo_csa_row #(.W(W)) u_csa (
            .x(store[PB + 3 * t]),
            .y(store[PB + 3 * t + 1]),
            .z(store[PB + 3 * t + 2]),
            .s(store[CB + 2 * t]),
            .c(store[CB + 2 * t + 1])
         );
      end
      for (genvar k = 0; k < LEFT; k++) begin : g_pass
         assign store[CB + 2 * TRI + k] = store[PB + 3 * TRI + k];
      end
   end

   assign sum_row   = store[level_base(R, LVLS)];
   assign carry_row = store[level_base(R, LVLS) + 1];
endmodule

// File: rtl/eo_cla_add.sv
module eo_cla_add
   import eo_mult_pkg::*;
#(
   parameter int W = 64,
   localparam int NG = (W + 3) / 4,
   localparam int NB = (NG + 3) / 4,
   localparam int GP = NB * 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum
);
   always_comb begin
      logic [GP-1:0]   g, p, cin_bit;
      logic [NB*4-1:0] grp_g, grp_p, grp_cin;
      logic [NB-1:0]   blk_g, blk_p;
      logic [NB:0]     blk_cin;
      logic [3:0]      tmp;
      g = '0;
      p = '0;
      g[W-1:0] = x & y;
      p[W-1:0] = x ^ y;
      // first level: group generate/propagate over 4 bits
      for (int k = 0; k < NB * 4; k++) begin
         tmp      = look4(g[4*k +: 4], p[4*k +: 4], 1'b0);
         grp_g[k] = tmp[3];
         grp_p[k] = &p[4*k +: 4];
      end
      // second level: block generate/propagate over 4 groups
      for (int m = 0; m < NB; m++) begin
         tmp      = look4(grp_g[4*m +: 4], grp_p[4*m +: 4], 1'b0);
         blk_g[m] = tmp[3];
         blk_p[m] = &grp_p[4*m +: 4];
      end
      blk_cin[0] = 1'b0;
      for (int m = 0; m < NB; m++) begin
         blk_cin[m+1] = blk_g[m] | (blk_p[m] & blk_cin[m]);
      end
      // group carries from block carries, bit carries from group carries
      for (int m = 0; m < NB; m++) begin
         tmp = look4(grp_g[4*m +: 4], grp_p[4*m +: 4], blk_cin[m]);
         grp_cin[4*m +: 4] = {tmp[2:0], blk_cin[m]};
      end
      for (int k = 0; k < NB * 4; k++) begin
         tmp = look4(g[4*k +: 4], p[4*k +: 4], grp_cin[k]);
         cin_bit[4*k +: 4] = {tmp[2:0], grp_cin[k]};
      end
      sum = p[W-1:0] ^ cin_bit[W-1:0];
   end
endmodule

// File: rtl/eo_csa_mult.sv
module eo_csa_mult #(
   parameter int N = 32,
   localparam int PW   = 2 * N,
   localparam int ROWS = 2 * N
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [N-1:0]  a_in,
   input  logic [N-1:0]  b_in,
   output logic          out_valid,
   output logic [PW-1:0] product
);
   if ((N % 2) != 0 || N < 4) begin : g_bad_width
      $error("eo_csa_mult: N must be even and at least 4");
   end

   logic [PW-1:0] pp_rows [ROWS];
   logic [PW-1:0] red_sum, red_carry, full_sum;

   eo_pp_gen #(.N(N)) u_pp (
      .a(a_in), .b(b_in), .rows(pp_rows)
   );

   eo_csa_tree #(.W(PW), .R(ROWS)) u_tree (
      .rows_in(pp_rows), .sum_row(red_sum), .carry_row(red_carry)
   );

   eo_cla_add #(.W(PW)) u_cla (
      .x(red_sum), .y(red_carry), .sum(full_sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         product   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) product <= full_sum;
      end
   end
endmodule

// File: rtl/eo_csa_mult_chk.sv
module eo_csa_mult_chk #(
   parameter int N = 32,
   localparam int PW = 2 * N
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [N-1:0]  a_in,
   input logic [N-1:0]  b_in,
   input logic          out_valid,
   input logic [PW-1:0] product
);
   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   p_exact_product_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (product == (PW'($past(a_in)) * PW'($past(b_in)))));

   p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_idle_no_valid_r3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(product));

   p_reset_clears_r5: assert property (@(posedge clk) disable iff (rst)
      rst_seen |-> (!out_valid && product == '0));
endmodule

bind eo_csa_mult eo_csa_mult_chk #(.N(N)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
   .out_valid(out_valid), .product(product)
);

// File: tb/eo_csa_mult_test.sv
module eo_csa_mult_test;
   localparam int N  = 32;
   localparam int PW = 64;
   localparam int NV = 11;
   localparam int NRAND = 10000;

   // tag codes: 6 = zero/power of two, 7 = all ones, 8 = parity-sparse
   localparam logic [N-1:0] TA [NV] = '{
      32'h0000_0000, 32'h1234_5678, 32'h0000_0001, 32'h8000_0000, 32'h0001_0000,
      32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5555_5555, 32'hAAAA_AAAA, 32'h5555_5555,
      32'hAAAA_AAAA };
   localparam logic [N-1:0] TB [NV] = '{
      32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'h0000_0100,
      32'hFFFF_FFFF, 32'h0000_0001, 32'h5555_5555, 32'hAAAA_AAAA, 32'hAAAA_AAAA,
      32'h5555_5555 };
   localparam logic [PW-1:0] TP [NV] = '{
      64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001,
      64'h4000_0000_0000_0000, 64'h0000_0000_0100_0000, 64'hFFFF_FFFE_0000_0001,
      64'h0000_0000_FFFF_FFFF, 64'h1C71_C71C_38E3_8E39, 64'h71C7_1C70_E38E_38E4,
      64'h38E3_8E38_71C7_1C72, 64'h38E3_8E38_71C7_1C72 };
   localparam int TK [NV] = '{6, 6, 6, 6, 6, 7, 7, 8, 8, 8, 8};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [N-1:0]  a_in = '0;
   logic [N-1:0]  b_in = '0;
   logic          out_valid;
   logic [PW-1:0] product;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   eo_csa_mult #(.N(N)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
      .out_valid(out_valid), .product(product)
   );

   task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   // drive a pair, then sample one edge later away from the edge
   task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
      @(negedge clk);
      a_in = a;
      b_in = b;
      in_valid = 1'b1;
      @(negedge clk);
      check({tag, " product R1/R2"}, product, PW'(a) * PW'(b));
      check({tag, " out_valid R3"}, PW'(out_valid), 64'd1);
   endtask

   initial begin
      logic [PW-1:0] held;
      logic [N-1:0]  ra, rb;
      string tag;
      repeat (3) @(negedge clk);
      check("R5 reset out_valid", PW'(out_valid), 64'd0);
      check("R5 reset product", product, 64'd0);
      rst = 1'b0;

      // vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         a_in = TA[i];
         b_in = TB[i];
         in_valid = 1'b1;
         @(negedge clk);
         case (TK[i])
            6: tag = "R6 zero/power-of-two";
            7: tag = "R7 all-ones";
            default: tag = "R8 parity-sparse";
         endcase
         check(tag, product, TP[i]);
         check("R3 out_valid after table vector", PW'(out_valid), 64'd1);
      end

      // hold: inputs change while in_valid is low
      @(negedge clk);
      held = product;
      in_valid = 1'b0;
      a_in = 32'hCAFE_F00D;
      b_in = 32'h1357_9BDF;
      @(negedge clk);
      check("R4 product held", product, held);
      check("R3 out_valid low when idle", PW'(out_valid), 64'd0);
      @(negedge clk);
      check("R4 product still held", product, held);

      // back-to-back acceptance
      apply(32'h0000_0003, 32'h0000_0005, "R2 burst 1");
      apply(32'h7FFF_FFFF, 32'h0000_0002, "R2 burst 2");
      apply(32'h4000_0000, 32'h0000_0004, "R6 power burst");

      // reset and capture in the same cycle: reset wins
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b1;
      a_in = 32'h0BAD_F00D;
      b_in = 32'h0000_0077;
      @(negedge clk);
      check("R5 reset beats in_valid out_valid", PW'(out_valid), 64'd0);
      check("R5 reset beats in_valid product", product, 64'd0);
      rst = 1'b0;
      in_valid = 1'b0;

      // random stream, some masked to a single parity
      for (int k = 0; k < NRAND; k++) begin
         ra = $urandom();
         rb = $urandom();
         case (k % 4)
            1: ra = ra & 32'h5555_5555;
            2: rb = rb & 32'hAAAA_AAAA;
            3: begin ra = ra & 32'hAAAA_AAAA; rb = rb & 32'h5555_5555; end
            default: ;
         endcase
         apply(ra, rb, (k % 4 == 0) ? "R1 random" : "R8 random sparse");
      end

      @(negedge clk);
      in_valid = 1'b0;
      finish_run();
   end

   initial begin
      #1_500_000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule